// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of event timers and the interrupt fabric. Each timer reports that it has fired with a one-clock strobe. The router turns that strobe into one of three results. A level-type timer sets a status bit and holds a wired line high. An edge-type timer pulses a wired line. A timer with message delivery enabled issues a 32-bit memory write request instead of driving any line. Software acknowledges level interrupts by writing ones to the status register, and only set bits are cleared.

A legacy mode takes over the first two timers. Timer 0 is forced onto line 0 and timer 1 onto line 8, whatever their route fields say. The external legacy-timer and RTC inputs are passed through to those two lines only while legacy mode is off. The RTC input is sampled every cycle, so leaving legacy mode shows its latest level at once. A separate output tells the external legacy timer whether it may run. Comparators and register decode are outside this block; they supply the fire strobes, the per-timer settings and the status write strobe.

Top module: `timer_irq_router`

## Requirements
- R1: After reset, every interrupt line is low, all status bits are 0, `msg_valid_o` is 0 and `pit_en_o` is 1.
- R2: When a timer fires with its own enable and the global enable set, the level type selected and message delivery off, its status bit becomes 1 and its routed line stays high until the status is cleared.
- R3: An edge-type fire (`level_i` bit 0) clears the timer's status bit and raises its routed line for exactly one clock.
- R4: A fire while the timer enable or the global enable is 0 drives no line and clears the timer's status bit. A `retire_i` strobe clears the status bit and lowers the line.
- R5: A status write clears exactly the bits that are written as 1 and currently set. Bits written as 0 are left unchanged.
- R6: While legacy mode is active, timer 0 drives line 0 and timer 1 drives line 8. All other timers, and all timers outside legacy mode, use their 5-bit route field: timer i uses bits [5i+4:5i] of `route_i`.
- R7: `pit_en_o` is 0 from the clock after `legacy_i` rises and 1 from the clock after it falls.
- R8: The sampled `pit_in_i` and `rtc_in_i` levels reach lines 0 and 8 only outside legacy mode. The RTC level is sampled in every mode, so leaving legacy mode puts its latest value on line 8.
- R9: A fire with message delivery enabled drives no line. It produces a one-clock `msg_valid_o` with `msg_addr_o` taken from bits [64i+63:64i+32] of `msg_route_i` and `msg_data_o` taken from bits [64i+31:64i].
- R10: Message requests from several timers in the same cycle are issued on consecutive clocks, lowest timer index first, and none are lost.
- R11: A rising edge on a timer's message-enable bit clears that timer's pending status. Its wired line drops as soon as the bit is 1.
- R12: A fire and a status-write clear for the same timer in the same cycle leave the status bit set by the fire.
- R13: A line driven by both a timer and a pass-through input is the OR of the two sources. Clearing one source leaves the line following the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fire_i | input | N_TMR | Per-timer fire strobe |
| retire_i | input | N_TMR | Per-timer clear strobe (timer deactivated) |
| tmr_en_i | input | N_TMR | Per-timer interrupt enable |
| level_i | input | N_TMR | Per-timer type: 1 level, 0 edge |
| msg_en_i | input | N_TMR | Per-timer message delivery enable |
| route_i | input | N_TMR*5 | Per-timer wired line select |
| msg_route_i | input | N_TMR*64 | Per-timer message route: address high half, data low half |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy mode select |
| sts_we_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | N_TMR | Status write data, one to clear |
| pit_in_i | input | 1 | External legacy-timer interrupt input |
| rtc_in_i | input | 1 | External RTC interrupt input |
| irq_o | output | N_LINE | Wired interrupt lines |
| pit_en_o | output | 1 | Enable for the external legacy timer |
| status_o | output | N_TMR | Status register value |
| msg_valid_o | output | 1 | Message write request, one clock per message |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
Every result is registered once. Status bits, line levels, edge pulses, pass-through levels and message requests all appear in the clock after the rising edge that samples the stimulus, and `pit_en_o` follows the legacy select on that same edge. The bench drives inputs on the falling edge, lets one rising edge pass and checks on the next falling edge. An edge pulse is therefore seen high at exactly one check and low at the next. A burst of message requests is checked on consecutive falling edges, one timer per clock.

// File: rtl/irq_route_pkg.sv
// Package: shared message word type and width helper for the timer
// interrupt router. Assumes 32-bit message address and data.
package irq_route_pkg;

    localparam int MSG_W = 32;

    typedef struct packed {
        logic [MSG_W-1:0] addr;
        logic [MSG_W-1:0] data;
    } msg_word_t;

    // Bits needed to select one of n lines (at least one bit).
    function automatic int line_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_evt_slot.sv
// Per-timer event slot: keeps one timer's status bit and edge pulse, and
// splits a fire between wired delivery and a message request.
// Assumes fire_i is a one-clock strobe. A fire wins over any clear
// source in the same cycle.
module irq_evt_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic retire_i,
    input  logic tmr_en_i,
    input  logic glb_en_i,
    input  logic level_i,
    input  logic msg_en_i,
    input  logic sts_clr_i,
    output logic status_o,
    output logic msg_req_o,
    output logic line_o
);
    logic msg_en_q;
    logic pulse_q;
    logic active;
    logic wired_fire;
    logic msg_rise;

    // Decode how a fire is delivered in this cycle.
    always_comb begin
        active     = tmr_en_i & glb_en_i;
        wired_fire = fire_i & active & ~msg_en_i;
        msg_req_o  = fire_i & active & msg_en_i;
        msg_rise   = msg_en_i & ~msg_en_q;
    end

    // Update status, edge pulse and message-enable history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= 1'b0;
            pulse_q  <= 1'b0;
            msg_en_q <= 1'b0;
        end else begin
            msg_en_q <= msg_en_i;
            pulse_q  <= wired_fire & ~level_i;
            if (fire_i) begin
                status_o <= wired_fire & level_i;
            end else if (retire_i || msg_rise || sts_clr_i) begin
                status_o <= 1'b0;
            end
        end
    end

    // Wired request; message delivery suppresses the line at once.
    assign line_o = (status_o | pulse_q) & ~msg_en_i;

endmodule

// File: rtl/irq_msg_arb.sv
// Message arbiter: collects message requests, issues one per clock with
// the lowest timer index first, and keeps the losers pending.
// Assumes no back-pressure on the message output.
module irq_msg_arb #(
    parameter int N = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [N-1:0]                          req_i,
    input  logic [N*2*irq_route_pkg::MSG_W-1:0]   words_i,
    output logic                                  valid_o,
    output irq_route_pkg::msg_word_t              word_o
);
    import irq_route_pkg::*;

    localparam int WORD_W = 2 * MSG_W;

    logic [N-1:0] pend_q;
    logic [N-1:0] cand;
    logic [N-1:0] grant;
    msg_word_t    sel;

    // Pick the lowest-index candidate and its route word.
    always_comb begin
        cand  = pend_q | req_i;
        grant = cand & (~cand + N'(1));
        sel   = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) sel = words_i[i*WORD_W +: WORD_W];
        end
    end

    // Register the issued message and retain unserved requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            pend_q  <= cand & ~grant;
            valid_o <= |cand;
            word_o  <= sel;
        end
    end

endmodule

// File: rtl/irq_line_fabric.sv
// Line fabric: ORs every timer's wired request onto its effective line,
// applies the legacy override for timers 0 and 1, and merges the
// pass-through inputs outside legacy mode. Purely combinational.
module irq_line_fabric #(
    parameter int N    = 4,
    parameter int NL   = 32,
    parameter int LW   = 5,
    parameter int LEG0 = 0,
    parameter int LEG1 = 8
) (
    input  logic [N-1:0]    drive_i,
    input  logic [N*LW-1:0] route_i,
    input  logic            leg_i,
    input  logic            pit_i,
    input  logic            rtc_i,
    output logic [NL-1:0]   lines_o
);
    // Build the line vector from all sources.
    always_comb begin
        logic [LW-1:0] eff;
        lines_o = '0;
        for (int i = 0; i < N; i++) begin
            eff = route_i[i*LW +: LW];
            if (leg_i && i == 0) eff = LW'(LEG0);
            if (leg_i && i == 1) eff = LW'(LEG1);
            if (drive_i[i] && int'(eff) < NL) lines_o[eff] = 1'b1;
        end
        if (!leg_i) begin
            lines_o[LEG0] = lines_o[LEG0] | pit_i;
            lines_o[LEG1] = lines_o[LEG1] | rtc_i;
        end
    end

endmodule

// File: rtl/timer_irq_router.sv
// Timer interrupt router top: one event slot per timer, a line fabric
// with legacy override and pass-through, and a message arbiter.
// Assumes the comparator logic supplies one-clock fire strobes and the
// bus decode supplies the status write strobe and data.
module timer_irq_router #(
    parameter int N_TMR        = 4,
    parameter int N_LINE       = 32,
    parameter int LEG_TMR_LINE = 0,
    parameter int LEG_RTC_LINE = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [N_TMR-1:0]                           fire_i,
    input  logic [N_TMR-1:0]                           retire_i,
    input  logic [N_TMR-1:0]                           tmr_en_i,
    input  logic [N_TMR-1:0]                           level_i,
    input  logic [N_TMR-1:0]                           msg_en_i,
    input  logic [N_TMR*irq_route_pkg::line_w(N_LINE)-1:0] route_i,
    input  logic [N_TMR*2*irq_route_pkg::MSG_W-1:0]    msg_route_i,
    input  logic                                       glb_en_i,
    input  logic                                       legacy_i,
    input  logic                                       sts_we_i,
    input  logic [N_TMR-1:0]                           sts_wdata_i,
    input  logic                                       pit_in_i,
    input  logic                                       rtc_in_i,
    output logic [N_LINE-1:0]                          irq_o,
    output logic                                       pit_en_o,
    output logic [N_TMR-1:0]                           status_o,
    output logic                                       msg_valid_o,
    output logic [irq_route_pkg::MSG_W-1:0]            msg_addr_o,
    output logic [irq_route_pkg::MSG_W-1:0]            msg_data_o
);
    import irq_route_pkg::*;

    localparam int LW = line_w(N_LINE);

    logic             leg_q;
    logic             pit_q;
    logic             rtc_q;
    logic [N_TMR-1:0] drive;
    logic [N_TMR-1:0] msg_req;
    msg_word_t        msg_word;

    // Stage the legacy select and sample the external lines every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg_q <= 1'b0;
            pit_q <= 1'b0;
            rtc_q <= 1'b0;
        end else begin
            leg_q <= legacy_i;
            pit_q <= pit_in_i;
            rtc_q <= rtc_in_i;
        end
    end

    assign pit_en_o = ~leg_q;

    // One event slot per timer.
    for (genvar g = 0; g < N_TMR; g++) begin : g_slot
        irq_evt_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .fire_i    (fire_i[g]),
            .retire_i  (retire_i[g]),
            .tmr_en_i  (tmr_en_i[g]),
            .glb_en_i  (glb_en_i),
            .level_i   (level_i[g]),
            .msg_en_i  (msg_en_i[g]),
            .sts_clr_i (sts_we_i & sts_wdata_i[g]),
            .status_o  (status_o[g]),
            .msg_req_o (msg_req[g]),
            .line_o    (drive[g])
        );
    end

    irq_line_fabric #(
        .N    (N_TMR),
        .NL   (N_LINE),
        .LW   (LW),
        .LEG0 (LEG_TMR_LINE),
        .LEG1 (LEG_RTC_LINE)
    ) u_fabric (
        .drive_i (drive),
        .route_i (route_i),
        .leg_i   (leg_q),
        .pit_i   (pit_q),
        .rtc_i   (rtc_q),
        .lines_o (irq_o)
    );

    irq_msg_arb #(
        .N (N_TMR)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (msg_req),
        .words_i (msg_route_i),
        .valid_o (msg_valid_o),
        .word_o  (msg_word)
    );

    assign msg_addr_o = msg_word.addr;
    assign msg_data_o = msg_word.data;

endmodule

// File: rtl/timer_irq_router_chk.sv
// Checker for the timer interrupt router: temporal properties on the
// top-level ports, attached by bind below.
module timer_irq_router_chk #(
    parameter int N_TMR  = 4,
    parameter int N_LINE = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_TMR-1:0]  fire_i,
    input logic [N_TMR-1:0]  retire_i,
    input logic [N_TMR-1:0]  tmr_en_i,
    input logic [N_TMR-1:0]  level_i,
    input logic [N_TMR-1:0]  msg_en_i,
    input logic              glb_en_i,
    input logic              legacy_i,
    input logic              sts_we_i,
    input logic [N_TMR-1:0]  sts_wdata_i,
    input logic [N_LINE-1:0] irq_o,
    input logic              pit_en_o,
    input logic [N_TMR-1:0]  status_o,
    input logic              msg_valid_o
);
    // R1: the cycle after reset every output is at its idle value.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (pit_en_o && irq_o == '0 && status_o == '0 && !msg_valid_o));

    // R7: the legacy-timer enable is the inverse of the previous legacy select.
    p_pit_follows_legacy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pit_en_o == !$past(legacy_i)));

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        // R2: an active level fire sets the status bit.
        p_level_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_i[g] && tmr_en_i[g] && glb_en_i && level_i[g] && !msg_en_i[g])
            |=> status_o[g]);

        // R3: an edge fire leaves the status bit clear.
        p_edge_no_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_i[g] && !level_i[g]) |=> !status_o[g]);

        // R4: a fire while disabled leaves the status bit clear.
        p_disabled_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_i[g] && (!tmr_en_i[g] || !glb_en_i)) |=> !status_o[g]);

        // R5: without a clear source a set status bit holds.
        p_status_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[g] && !fire_i[g] && !retire_i[g] && !msg_en_i[g]
             && !(sts_we_i && sts_wdata_i[g])) |=> status_o[g]);

        // R9: an active fire with message delivery yields a message next cycle.
        p_msg_issued_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_i[g] && tmr_en_i[g] && glb_en_i && msg_en_i[g]) |=> msg_valid_o);
    end

endmodule

bind timer_irq_router timer_irq_router_chk #(
    .N_TMR  (N_TMR),
    .N_LINE (N_LINE)
) u_chk (.*);

// File: tb/timer_irq_router_bench.sv
module timer_irq_router_bench;

    localparam int N_TMR  = 4;
    localparam int N_LINE = 32;
    localparam int LW     = 5;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [N_TMR-1:0]     fire_i, retire_i, tmr_en_i, level_i, msg_en_i;
    logic [N_TMR*LW-1:0]  route_i;
    logic [N_TMR*64-1:0]  msg_route_i;
    logic                 glb_en_i, legacy_i, sts_we_i;
    logic [N_TMR-1:0]     sts_wdata_i;
    logic                 pit_in_i, rtc_in_i;
    logic [N_LINE-1:0]    irq_o;
    logic                 pit_en_o;
    logic [N_TMR-1:0]     status_o;
    logic                 msg_valid_o;
    logic [31:0]          msg_addr_o, msg_data_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    timer_irq_router u_timer_irq_router (
        .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .retire_i(retire_i),
        .tmr_en_i(tmr_en_i), .level_i(level_i), .msg_en_i(msg_en_i),
        .route_i(route_i), .msg_route_i(msg_route_i), .glb_en_i(glb_en_i),
        .legacy_i(legacy_i), .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
        .pit_in_i(pit_in_i), .rtc_in_i(rtc_in_i), .irq_o(irq_o),
        .pit_en_o(pit_en_o), .status_o(status_o), .msg_valid_o(msg_valid_o),
        .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
    );

    // Stimulus row and the outputs expected one clock later.
    typedef struct packed {
        logic [3:0]  fire;
        logic [3:0]  lvl;
        logic [3:0]  msg;
        logic        we;
        logic [3:0]  wd;
        logic        leg;
        logic        pit;
        logic        rtc;
        logic [31:0] x_irq;
        logic [3:0]  x_sts;
        logic        x_mv;
    } vec_t;

    // Routes: t0 -> 3, t1 -> 5, t2 -> 10, t3 -> 8.
    localparam vec_t TBL [14] = '{
        '{4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 32'h0000_0008, 4'b0001, 1'b0}, // level t0
        '{4'b0100, 4'b0001, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 32'h0000_0408, 4'b0001, 1'b0}, // edge t2
        '{4'b0000, 4'b0001, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 32'h0000_0008, 4'b0001, 1'b0}, // pulse gone
        '{4'b0000, 4'b0001, 4'b0000, 1'b1, 4'b1110, 1'b0, 1'b0, 1'b0, 32'h0000_0008, 4'b0001, 1'b0}, // w1c other bits
        '{4'b0000, 4'b0001, 4'b0000, 1'b1, 4'b0001, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 4'b0000, 1'b0}, // w1c t0
        '{4'b1010, 4'b1010, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 32'h0000_0120, 4'b1010, 1'b0}, // level t1,t3
        '{4'b0000, 4'b1010, 4'b0000, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 32'h0000_0100, 4'b1010, 1'b0}, // legacy reroute
        '{4'b0000, 4'b1010, 4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 32'h0000_0100, 4'b1010, 1'b0}, // inputs gated
        '{4'b0000, 4'b1010, 4'b0000, 1'b1, 4'b1010, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'b0000, 1'b0}, // clear, gated
        '{4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 32'h0000_0101, 4'b0000, 1'b0}, // leave legacy
        '{4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 4'b0000, 1'b0}, // inputs low
        '{4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 4'b0001, 1'b0}, // t0 on line 0
        '{4'b0000, 4'b0001, 4'b0000, 1'b1, 4'b0001, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 4'b0000, 1'b0}, // clear t0
        '{4'b0100, 4'b0100, 4'b0100, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 4'b0000, 1'b1}  // message t2
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        fire_i = '0; retire_i = '0; msg_en_i = '0; level_i = '0;
        tmr_en_i = '1; glb_en_i = 1'b1; legacy_i = 1'b0;
        sts_we_i = 1'b0; sts_wdata_i = '0; pit_in_i = 1'b0; rtc_in_i = 1'b0;
    endtask

    function automatic logic [63:0] route_word(input int i);
        return {32'hA000_0000 + 32'(i), 32'h5A00_0000 + 32'(i) * 32'h11};
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        route_i = {5'd8, 5'd10, 5'd5, 5'd3};
        for (int i = 0; i < N_TMR; i++) msg_route_i[i*64 +: 64] = route_word(i);
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset.
        chk("R1 irq", 64'(irq_o), 64'h0);
        chk("R1 status", 64'(status_o), 64'h0);
        chk("R1 msg_valid", 64'(msg_valid_o), 64'h0);
        chk("R1 pit_en", 64'(pit_en_o), 64'h1);

        // Table walk: R2 R3 R5 R6 R7 R8 R9.
        for (int r = 0; r < 14; r++) begin
            fire_i = TBL[r].fire; level_i = TBL[r].lvl; msg_en_i = TBL[r].msg;
            sts_we_i = TBL[r].we; sts_wdata_i = TBL[r].wd; legacy_i = TBL[r].leg;
            pit_in_i = TBL[r].pit; rtc_in_i = TBL[r].rtc;
            step();
            chk($sformatf("R2/R3/R5/R6/R8 row %0d irq", r), 64'(irq_o), 64'(TBL[r].x_irq));
            chk($sformatf("R2/R3/R5 row %0d status", r), 64'(status_o), 64'(TBL[r].x_sts));
            chk($sformatf("R9 row %0d msg_valid", r), 64'(msg_valid_o), 64'(TBL[r].x_mv));
            chk($sformatf("R7 row %0d pit_en", r), 64'(pit_en_o), 64'(!TBL[r].leg));
            if (TBL[r].x_mv) begin
                chk("R9 msg addr", 64'(msg_addr_o), 64'(route_word(2) >> 32));
                chk("R9 msg data", 64'(msg_data_o), 64'(route_word(2) & 64'hFFFF_FFFF));
            end
        end
        idle();
        step();

        // R4: disabled fires and retire strobe.
        glb_en_i = 1'b0; fire_i = 4'b0001; level_i = 4'b0001;
        step();
        chk("R4 global off status", 64'(status_o), 64'h0);
        chk("R4 global off irq", 64'(irq_o), 64'h0);
        idle(); tmr_en_i = 4'b1101; fire_i = 4'b0010;
        step();
        chk("R4 timer off irq", 64'(irq_o), 64'h0);
        idle(); fire_i = 4'b0100; level_i = 4'b0100;
        step();
        chk("R4 setup status", 64'(status_o), 64'h4);
        idle(); retire_i = 4'b0100;
        step();
        chk("R4 retire status", 64'(status_o), 64'h0);
        chk("R4 retire irq", 64'(irq_o), 64'h0);

        // R10: four simultaneous message fires.
        idle(); msg_en_i = 4'b1111; fire_i = 4'b1111;
        step();
        fire_i = '0;
        for (int i = 0; i < N_TMR; i++) begin
            chk("R10 burst valid", 64'(msg_valid_o), 64'h1);
            chk("R10 burst addr", 64'(msg_addr_o), 64'(route_word(i) >> 32));
            chk("R10 burst data", 64'(msg_data_o), 64'(route_word(i) & 64'hFFFF_FFFF));
            chk("R9 no wired line", 64'(irq_o), 64'h0);
            step();
        end
        chk("R10 burst end", 64'(msg_valid_o), 64'h0);

        // R11: rising message enable clears pending status.
        idle(); fire_i = 4'b0100; level_i = 4'b0100;
        step();
        chk("R11 setup status", 64'(status_o), 64'h4);
        idle(); msg_en_i = 4'b0100;
        step();
        chk("R11 status", 64'(status_o), 64'h0);
        chk("R11 irq", 64'(irq_o), 64'h0);

        // R12: fire beats a same-cycle status clear.
        idle(); fire_i = 4'b0001; level_i = 4'b0001;
        step();
        sts_we_i = 1'b1; sts_wdata_i = 4'b0001;
        step();
        chk("R12 status", 64'(status_o), 64'h1);
        idle(); sts_we_i = 1'b1; sts_wdata_i = 4'b0001;
        step();

        // R13: timer 3 and RTC pass-through share line 8.
        idle(); fire_i = 4'b1000; level_i = 4'b1000; rtc_in_i = 1'b1;
        step();
        chk("R13 both", 64'(irq_o), 64'h100);
        idle(); rtc_in_i = 1'b1; sts_we_i = 1'b1; sts_wdata_i = 4'b1000;
        step();
        chk("R13 rtc only", 64'(irq_o), 64'h100);
        chk("R13 status cleared", 64'(status_o), 64'h0);
        idle();
        step();
        chk("R13 none", 64'(irq_o), 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule